// File: doc/BRIEF.md
# TDM Transmit Slot Mask Controller

This block decides, slot by slot, whether the data pins of a time-division-multiplexed serial audio transmitter drive or float. A processor programs a 32-bit slot-enable mask through two 16-bit register halves. Bit N of the mask governs slot N. The processor also feeds a holding register, and can post a skip strobe that floats the next slot regardless of the mask. The surrounding transmitter supplies frame-start and slot-start strobes with a slot index. The block answers with a one-cycle load pulse that moves the holding value into the external shift register, a per-pin output enable for the slot, and sticky empty and underrun flags.

The written mask is held in a shadow copy. The copy used for slot decisions is refreshed only on frame start, so a frame already in progress is never disturbed by a mask write. A masked slot still produces a load pulse but raises no flag. The holding value stays pending after a masked slot and is sent in the next enabled slot. Slot indices at or beyond the configured frame length are ignored. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `tdm_slot_mask`

## Requirements
- R1: After reset both mask halves read 0xFFFF, every pin output enable is 0, and the empty and underrun flags are 0.
- R2: Register address 0 writes and reads the low mask half (slots 0 to 15, bit N for slot N). Address 1 writes and reads the high half (slots 16 to 31, bit N-16 for slot N). A read returns the value last written, and the data bits above bit 15 read as zero.
- R3: The mask used for slot decisions is loaded from the written mask on frame_start, and a slot starting in that same cycle already uses the new mask. Until then, slots keep the previous mask.
- R4: A slot_start whose index is below slots_cfg produces a shift_load pulse of one cycle in the following cycle, with shift_data equal to the holding register. When the slot is enabled and not skipped, pin_oe equals pin_en for the slot and tx_empty is set.
- R5: In a slot disabled by the mask, the load pulse and data still appear, pin_oe is all zero, and neither tx_empty nor tx_underrun becomes set.
- R6: When an enabled, unskipped slot begins and the holding register (address 2) has not been written since the last slot that consumed it, tx_underrun is set. A holding write clears both tx_empty and tx_underrun.
- R7: A write to address 3 (any data) floats all pins for the next valid slot even if the mask enables it. That slot sets tx_empty if enabled, never raises tx_underrun, and leaves the holding data pending. The skip is used up by that slot.
- R8: A slot_start whose index is at or above slots_cfg produces no load pulse, leaves pin_oe and the flags unchanged, and does not use up a pending skip.
- R9: Holding data written before a masked slot stays pending and is loaded and driven in the next enabled slot with no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask low, 1 mask high, 2 holding data, 3 skip |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for the mask halves, zero for other addresses |
| frame_start | input | 1 | Frame boundary strobe; applies the written mask |
| slot_start | input | 1 | Slot boundary strobe |
| slot_idx | input | SLOT_W | Index of the starting slot |
| slots_cfg | input | SLOT_W+1 | Number of slots in a frame |
| pin_en | input | NUM_PINS | Transmitters in use |
| shift_load | output | 1 | Pulse: load shift_data into the shift register |
| shift_data | output | DATA_W | Data for the shift register |
| pin_oe | output | NUM_PINS | Per-pin output enable for the current slot |
| tx_empty | output | 1 | Holding register needs new data |
| tx_underrun | output | 1 | An enabled slot found no new data |

## Verification
The slot decision is run through frames in which enabled slots alternate with mask-disabled slots, skipped slots and out-of-range indices. The difference between a masked slot and a skipped one shows in the flags and in whether the holding data stays pending. Mask writes are issued mid-frame and then on a frame boundary that coincides with a slot. This separates shadow-copy behaviour from immediate use of the mask. Holding writes are placed before some slots and left out before others, which tells underrun detection apart from the plain empty request. A run with a frame length of 32 covers the high mask half.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    A_MASK_LO = 2'd0,
    A_MASK_HI = 2'd1,
    A_HOLD    = 2'd2,
    A_SKIP    = 2'd3
  } tsm_addr_e;
endpackage

// File: rtl/tsm_rst_sync.sv
module tsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tsm_mask_regs.sv
module tsm_mask_regs
  import tsm_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wen,
  input  logic [1:0]            addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  frame_start,
  output logic [DATA_W-1:0]     rdata,
  output logic [2*HALF_W-1:0]   act_mask,
  output logic [2*HALF_W-1:0]   eff_mask
);
  localparam int MASK_W = 2 * HALF_W;

  tsm_addr_e         sel;
  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [MASK_W-1:0] act_q, act_d;

  assign sel = tsm_addr_e'(addr);

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    act_d = act_q;
    if (wen && sel == A_MASK_LO) lo_d = wdata[HALF_W-1:0];
    if (wen && sel == A_MASK_HI) hi_d = wdata[HALF_W-1:0];
    if (frame_start)             act_d = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '1;
      hi_q  <= '1;
      act_q <= '1;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      A_MASK_LO: rdata[HALF_W-1:0] = lo_q;
      A_MASK_HI: rdata[HALF_W-1:0] = hi_q;
      default:   rdata = '0;
    endcase
  end

  assign act_mask = act_q;
  assign eff_mask = frame_start ? {hi_q, lo_q} : act_q;
endmodule

// File: rtl/tsm_hold_path.sv
module tsm_hold_path #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              slot_go,
  input  logic              consume,
  output logic              fresh,
  output logic              shift_load,
  output logic [DATA_W-1:0] shift_data
);
  logic [DATA_W-1:0] hold_q, hold_d, sdata_q, sdata_d;
  logic              fresh_q, fresh_d, load_q, load_d;

  always_comb begin
    hold_d  = hold_q;
    sdata_d = sdata_q;
    fresh_d = fresh_q;
    load_d  = slot_go;
    if (slot_go) sdata_d = hold_q;
    if (hold_we) begin
      hold_d  = wdata;
      fresh_d = 1'b1;
    end else if (consume) begin
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sdata_q <= '0;
      fresh_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      sdata_q <= sdata_d;
      fresh_q <= fresh_d;
      load_q  <= load_d;
    end
  end

  assign fresh      = fresh_q;
  assign shift_load = load_q;
  assign shift_data = sdata_q;
endmodule

// File: rtl/tsm_slot_ctrl.sv
module tsm_slot_ctrl #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_start,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic [SLOT_W:0]      slots_cfg,
  input  logic [NUM_SLOTS-1:0] eff_mask,
  input  logic                 skip_we,
  input  logic                 hold_we,
  input  logic                 fresh,
  output logic                 slot_go,
  output logic                 consume,
  output logic                 skip_pend,
  output logic                 drive,
  output logic                 tx_empty,
  output logic                 tx_underrun
);
  logic slot_en;
  logic skip_q, skip_d, drive_q, drive_d;
  logic empty_q, empty_d, under_q, under_d;

  assign slot_go = slot_start && ({1'b0, slot_idx} < slots_cfg);
  assign slot_en = eff_mask[slot_idx];
  assign consume = slot_go && slot_en && !skip_q;

  always_comb begin
    skip_d  = skip_q;
    drive_d = drive_q;
    empty_d = empty_q;
    under_d = under_q;
    if (slot_go) begin
      skip_d  = 1'b0;
      drive_d = slot_en && !skip_q;
    end
    if (skip_we) skip_d = 1'b1;
    if (slot_go && slot_en) empty_d = 1'b1;
    else if (hold_we)       empty_d = 1'b0;
    if (consume)            under_d = !fresh;
    else if (hold_we)       under_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q  <= 1'b0;
      drive_q <= 1'b0;
      empty_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      skip_q  <= skip_d;
      drive_q <= drive_d;
      empty_q <= empty_d;
      under_q <= under_d;
    end
  end

  assign skip_pend   = skip_q;
  assign drive       = drive_q;
  assign tx_empty    = empty_q;
  assign tx_underrun = under_q;
endmodule

// File: rtl/tdm_slot_mask.sv
module tdm_slot_mask
  import tsm_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_PINS = 4,
  parameter int SLOT_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                frame_start,
  input  logic                slot_start,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic [SLOT_W:0]     slots_cfg,
  input  logic [NUM_PINS-1:0] pin_en,
  output logic                shift_load,
  output logic [DATA_W-1:0]   shift_data,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                tx_empty,
  output logic                tx_underrun
);
  localparam int NUM_SLOTS = 2 * HALF_W;

  logic                 rst_sync_n;
  logic [NUM_SLOTS-1:0] act_mask, eff_mask;
  logic                 hold_we, skip_we, fresh, slot_go, consume, skip_pend, drive;

  assign hold_we = reg_wen && (tsm_addr_e'(reg_addr) == A_HOLD);
  assign skip_we = reg_wen && (tsm_addr_e'(reg_addr) == A_SKIP);

  tsm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tsm_mask_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .frame_start(frame_start), .rdata(reg_rdata),
    .act_mask(act_mask), .eff_mask(eff_mask)
  );

  tsm_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .slot_start(slot_start), .slot_idx(slot_idx),
    .slots_cfg(slots_cfg), .eff_mask(eff_mask), .skip_we(skip_we),
    .hold_we(hold_we), .fresh(fresh), .slot_go(slot_go), .consume(consume),
    .skip_pend(skip_pend), .drive(drive), .tx_empty(tx_empty),
    .tx_underrun(tx_underrun)
  );

  tsm_hold_path #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .hold_we(hold_we), .wdata(reg_wdata),
    .slot_go(slot_go), .consume(consume), .fresh(fresh),
    .shift_load(shift_load), .shift_data(shift_data)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe[p] = pin_en[p] & drive;
  end
endmodule

// File: rtl/tdm_slot_mask_chk.sv
module tdm_slot_mask_chk
  import tsm_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_PINS = 4,
  parameter int SLOT_W   = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wen,
  input logic [1:0]            reg_addr,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic                  frame_start,
  input logic                  slot_start,
  input logic [SLOT_W-1:0]     slot_idx,
  input logic [SLOT_W:0]       slots_cfg,
  input logic [2*HALF_W-1:0]   act_mask,
  input logic                  skip_pend,
  input logic                  shift_load,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic                  tx_empty,
  input logic                  tx_underrun
);
  logic slot_ok, slot_out, hold_wr;
  assign slot_ok  = slot_start && ({1'b0, slot_idx} < slots_cfg);
  assign slot_out = slot_start && !({1'b0, slot_idx} < slots_cfg);
  assign hold_wr  = reg_wen && (tsm_addr_e'(reg_addr) == A_HOLD);

  assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:HALF_W] == '0);

  assert_mask_held_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mask));

  assert_load_follows_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_load |-> $past(slot_ok));

  assert_masked_slot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ok && !frame_start && !act_mask[slot_idx]
      |=> pin_oe == '0 && !$rose(tx_empty) && !$rose(tx_underrun));

  assert_hold_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr && !slot_start |=> !tx_empty && !tx_underrun);

  assert_skip_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ok && skip_pend |=> pin_oe == '0 && !$rose(tx_underrun));

  assert_out_of_range_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_out && !hold_wr |=> !shift_load && $stable(tx_empty) && $stable(tx_underrun));
endmodule

bind tdm_slot_mask tdm_slot_mask_chk #(
  .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .frame_start(frame_start), .slot_start(slot_start),
  .slot_idx(slot_idx), .slots_cfg(slots_cfg), .act_mask(act_mask),
  .skip_pend(skip_pend), .shift_load(shift_load), .pin_oe(pin_oe),
  .tx_empty(tx_empty), .tx_underrun(tx_underrun)
);

// File: tb/tdm_slot_mask_test.sv
module tdm_slot_mask_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 24;
  localparam int NUM_PINS = 4;
  localparam int SLOT_W = 5;
  localparam logic [NUM_PINS-1:0] PINS = 4'b1011;

  typedef struct {
    logic [DATA_W-1:0]   data;
    logic [NUM_PINS-1:0] oe;
    logic                empty;
    logic                under;
    string               req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wen;
  logic [1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic frame_start, slot_start;
  logic [SLOT_W-1:0] slot_idx;
  logic [SLOT_W:0] slots_cfg;
  logic [NUM_PINS-1:0] pin_en;
  logic shift_load;
  logic [DATA_W-1:0] shift_data;
  logic [NUM_PINS-1:0] pin_oe;
  logic tx_empty, tx_underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  logic [31:0] m_wmask, m_amask;
  logic [DATA_W-1:0] m_hold;
  bit m_fresh, m_skip, m_empty, m_under;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_mask #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .SLOT_W(SLOT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .slot_start(slot_start), .slot_idx(slot_idx), .slots_cfg(slots_cfg),
    .pin_en(pin_en), .shift_load(shift_load), .shift_data(shift_data),
    .pin_oe(pin_oe), .tx_empty(tx_empty), .tx_underrun(tx_underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: m_wmask[15:0]  = d[15:0];
      2'd1: m_wmask[31:16] = d[15:0];
      2'd2: begin m_hold = d; m_fresh = 1'b1; m_empty = 1'b0; m_under = 1'b0; end
      default: m_skip = 1'b1;
    endcase
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [DATA_W-1:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic slot(input bit frame, input int idx, input string req);
    exp_t e;
    bit en;
    @(negedge clk);
    frame_start = frame; slot_start = 1'b1; slot_idx = SLOT_W'(idx);
    if (frame) m_amask = m_wmask;
    if (idx < int'(slots_cfg)) begin
      en = m_amask[idx];
      if (en) m_empty = 1'b1;
      if (en && !m_skip) begin
        m_under = !m_fresh;
        m_fresh = 1'b0;
      end
      e.data = m_hold;
      e.oe = (en && !m_skip) ? PINS : '0;
      e.empty = m_empty;
      e.under = m_under;
      e.req = req;
      m_skip = 1'b0;
      sb.push_back(e);
    end
    @(negedge clk);
    frame_start = 1'b0; slot_start = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && shift_load) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual=unexpected load expected=no load");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " data"}, 32'(shift_data), 32'(e.data));
        check({e.req, " oe"}, 32'(pin_oe), 32'(e.oe));
        check({e.req, " empty"}, 32'(tx_empty), 32'(e.empty));
        check({e.req, " underrun"}, 32'(tx_underrun), 32'(e.under));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_start = 1'b0; slot_start = 1'b0; slot_idx = '0;
    slots_cfg = 6'd8; pin_en = PINS;
    m_wmask = '1; m_amask = '1; m_hold = '0;
    m_fresh = 0; m_skip = 0; m_empty = 0; m_under = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd("R1 low half", 2'd0, 24'h00FFFF);
    rd("R1 high half", 2'd1, 24'h00FFFF);
    check("R1 oe", 32'(pin_oe), 32'h0);
    check("R1 empty", 32'(tx_empty), 32'h0);
    check("R1 underrun", 32'(tx_underrun), 32'h0);

    // R4 enabled slots, R6 underrun
    wr(2'd2, 24'hA0A0A0);
    slot(1, 0, "R4 enabled slot");
    slot(0, 1, "R6 underrun");
    wr(2'd2, 24'hB1B1B1);
    check("R6 empty cleared", 32'(tx_empty), 32'h0);
    check("R6 underrun cleared", 32'(tx_underrun), 32'h0);

    // R3 mid-frame mask write has no effect until frame start
    wr(2'd0, 24'h00FFFD);
    slot(0, 2, "R3 old mask");
    wr(2'd2, 24'hC2C2C2);
    slot(1, 0, "R3 new frame");
    // R5 masked slot, R9 pending data
    wr(2'd2, 24'hD3D3D3);
    slot(0, 1, "R5 masked slot");
    slot(0, 2, "R9 next enabled");

    // R2 register readback
    rd("R2 low readback", 2'd0, 24'h00FFFD);
    wr(2'd1, 24'hAB2345);
    rd("R2 high upper zero", 2'd1, 24'h002345);
    wr(2'd1, 24'h00FFEF);
    rd("R2 high readback", 2'd1, 24'h00FFEF);

    // R7 skip strobe
    wr(2'd2, 24'hE4E4E4);
    wr(2'd3, 24'h000000);
    slot(0, 3, "R7 skipped slot");
    slot(0, 4, "R7 after skip");

    // R8 out-of-range index keeps skip pending
    wr(2'd3, 24'h000000);
    slot(0, 10, "R8 ignored");
    check("R8 no load", 32'(shift_load), 32'h0);
    check("R8 oe kept", 32'(pin_oe), 32'(PINS));
    slot(0, 5, "R8 skip kept");
    slot(0, 6, "R6 underrun again");

    // high half with 32 slots
    slots_cfg = 6'd32;
    wr(2'd2, 24'hF5F5F5);
    slot(1, 16, "R2 slot 16 enabled");
    slot(0, 20, "R5 slot 20 masked");
    slot(0, 31, "R6 slot 31 underrun");

    // R3 mask applied on a coinciding frame start
    wr(2'd0, 24'h00FFFE);
    wr(2'd2, 24'h123456);
    slot(1, 0, "R3 coincident frame");
    slot(0, 1, "R9 after masked slot0");

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule